// File: doc/BRIEF.md
# Interrupt Acknowledge Vector Sequencer

This block sits beside the priority logic of an interrupt controller and answers the processor's acknowledge cycles. It counts the acknowledge pulses. On each pulse that carries data, it places the matching vector byte on the data bus and asserts a data enable. At the start of the first pulse it raises a one-cycle freeze strobe, so the priority logic stops resolving while the sequence runs. At that same point it captures the granted level and the system mode, and both stay fixed until the sequence ends.

Two system modes are supported. In call mode the processor issues three pulses and receives:

- a subroutine-call opcode;
- the low byte of the routine address, with the level number spliced in at a position set by the routine interval (4 or 8 bytes);
- the programmed high address byte.

In pointer mode the processor issues two pulses. The first carries no data. The second returns an 8-bit type pointer built from the five programmed high bits and the level.

When automatic end-of-interrupt is selected, a one-cycle clear pulse is issued once the final pulse of the sequence ends. The captured level is presented alongside it.

The acknowledge input is sampled on the block clock and is active high. All outputs are registered. They change on the clock edge that first sees the acknowledge input rise or fall.

Top module: `intack_vector_seq`

## Requirements
- R1: After reset, and after a reinit pulse, the data byte is 0, the data enable, freeze and clear outputs are 0, and the next acknowledge pulse is treated as the first of a sequence.
- R2: In call mode (mode input 0) the first pulse drives 8'hCD with the data enable high, and freeze is high for exactly the one cycle after the pulse is first seen.
- R3: In call mode with the interval input at 1 (4-byte spacing), the second pulse drives {base_lo[2:0], level[2:0], 2'b00}.
- R4: In call mode with the interval input at 0 (8-byte spacing), the second pulse drives {base_lo[2:1], level[2:0], 3'b000}; base_lo[0] has no effect.
- R5: In call mode the third pulse drives base_hi[7:0].
- R6: In pointer mode (mode input 1) the first pulse drives no data (enable low, byte 0) and raises freeze for one cycle.
- R7: In pointer mode the second pulse drives {base_hi[7:3], level[2:0]}, whatever the interval input.
- R8: With the auto-clear input high, the clear output pulses for one cycle on the edge that sees the final pulse fall (third in call mode, second in pointer mode), with the captured level on the level output; it stays low otherwise and when auto-clear is low.
- R9: The data enable is high only while an acknowledge pulse that carries data is active; between pulses the enable is low and the byte is 0.
- R10: The level is captured at the first pulse; later changes on the level input do not affect the bytes of that sequence.
- R11: After the final pulse the sequencer returns to idle, so the next pulse is a first pulse again.
- R12: The mode input is captured at the first pulse; changing it mid-sequence does not change the number or content of the remaining pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reinit | input | 1 | Synchronous return to idle (initialization restart) |
| ack_i | input | 1 | Acknowledge strobe, high while a pulse is active |
| ptr_mode_i | input | 1 | 1 = two-pulse pointer mode, 0 = three-pulse call mode |
| ival4_i | input | 1 | 1 = 4-byte routine spacing, 0 = 8-byte |
| base_lo_i | input | 3 | Programmed low address bits (A7..A5) |
| base_hi_i | input | 8 | Programmed high address byte (A15..A8); top five bits form the pointer base |
| level_i | input | 3 | Level granted by the priority logic |
| aeoi_i | input | 1 | Automatic end-of-interrupt select |
| data_o | output | 8 | Vector byte |
| data_oe_o | output | 1 | Data bus enable |
| freeze_o | output | 1 | One-cycle strobe at the start of a sequence |
| eoi_clr_o | output | 1 | One-cycle in-service clear pulse |
| lvl_o | output | 3 | Level captured for the current sequence |

## Verification
The bench targets the level splice at both intervals. A design that put the level at the wrong offset, or used A5 with 8-byte spacing, would return a wrong low address byte. It checks that pointer mode leaves the bus quiet on its first pulse and ends after two pulses. A counter that assumed three pulses would hang, or would emit the clear pulse one pulse late. It also changes the level and mode inputs in the middle of a sequence, and raises reinit after a single pulse. A design that did not capture its inputs, or did not reset its count, would then produce bytes from the wrong sequence step.

// File: rtl/ivs_pkg.sv
package ivs_pkg;
  localparam int BYTE_W = 8;
  localparam logic [BYTE_W-1:0] CALL_OPCODE = 8'hCD;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_ONE   = 2'd1,
    PH_TWO   = 2'd2,
    PH_THREE = 2'd3
  } ph_e;
endpackage

// File: rtl/ivs_ack_edge.sv
module ivs_ack_edge (
  input  logic clk,
  input  logic rst,
  input  logic ack_i,
  output logic rise_o,
  output logic fall_o
);
  logic ack_q;

  always_ff @(posedge clk) begin
    if (rst) ack_q <= 1'b0;
    else     ack_q <= ack_i;
  end

  assign rise_o = ack_i & ~ack_q;
  assign fall_o = ~ack_i & ack_q;
endmodule

// File: rtl/ivs_phase_ctr.sv
module ivs_phase_ctr
  import ivs_pkg::*;
#(
  parameter int LVL_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             reinit,
  input  logic             rise_i,
  input  logic             fall_i,
  input  logic             ptr_mode_i,
  input  logic [LVL_W-1:0] level_i,
  output ph_e              ph_nxt_o,
  output logic             mode_eff_o,
  output logic             mode_o,
  output logic             start_o,
  output logic             last_o,
  output logic [LVL_W-1:0] lvl_o
);
  ph_e              phase_q;
  logic             mode_q;
  logic [LVL_W-1:0] lvl_q;
  logic             is_final;

  always_comb begin
    unique case (phase_q)
      PH_IDLE: ph_nxt_o = PH_ONE;
      PH_ONE:  ph_nxt_o = PH_TWO;
      default: ph_nxt_o = PH_THREE;
    endcase
  end

  assign mode_eff_o = (phase_q == PH_IDLE) ? ptr_mode_i : mode_q;
  assign is_final   = (phase_q == PH_THREE) || ((phase_q == PH_TWO) && mode_q);
  assign start_o    = rise_i && (phase_q == PH_IDLE);
  assign last_o     = fall_i && is_final;
  assign mode_o     = mode_q;
  assign lvl_o      = lvl_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= PH_IDLE;
      mode_q  <= 1'b0;
      lvl_q   <= '0;
    end else if (reinit) begin
      phase_q <= PH_IDLE;
    end else if (rise_i) begin
      phase_q <= ph_nxt_o;
      if (phase_q == PH_IDLE) begin
        mode_q <= ptr_mode_i;
        lvl_q  <= level_i;
      end
    end else if (last_o) begin
      phase_q <= PH_IDLE;
    end
  end

  AST_PTR_NO_THIRD: assert property (@(posedge clk) disable iff (rst)
    mode_q |-> (phase_q != PH_THREE)); // R11

  AST_LVL_ONLY_AT_START: assert property (@(posedge clk) disable iff (rst)
    !$stable(lvl_q) |-> $past(start_o)); // R10

  AST_MODE_ONLY_AT_START: assert property (@(posedge clk) disable iff (rst)
    !$stable(mode_q) |-> $past(start_o)); // R12
endmodule

// File: rtl/ivs_byte_fmt.sv
module ivs_byte_fmt
  import ivs_pkg::*;
#(
  parameter int LVL_W = 3,
  localparam int LO_W = BYTE_W - LVL_W - 2
) (
  input  ph_e               ph_i,
  input  logic              ptr_mode_i,
  input  logic              ival4_i,
  input  logic [LO_W-1:0]   base_lo_i,
  input  logic [BYTE_W-1:0] base_hi_i,
  input  logic [LVL_W-1:0]  lvl_i,
  output logic [BYTE_W-1:0] byte_o,
  output logic              has_data_o
);
  localparam int PTR_W = BYTE_W - LVL_W;

  logic [BYTE_W-1:0] lo_byte;

  always_comb begin
    if (ival4_i) lo_byte = {base_lo_i, lvl_i, 2'b00};
    else         lo_byte = {base_lo_i[LO_W-1:1], lvl_i, 3'b000};
  end

  always_comb begin
    byte_o     = '0;
    has_data_o = 1'b0;
    if (ptr_mode_i) begin
      if (ph_i == PH_TWO) begin
        byte_o     = {base_hi_i[BYTE_W-1:BYTE_W-PTR_W], lvl_i};
        has_data_o = 1'b1;
      end
    end else begin
      unique case (ph_i)
        PH_ONE:   begin byte_o = CALL_OPCODE; has_data_o = 1'b1; end
        PH_TWO:   begin byte_o = lo_byte;     has_data_o = 1'b1; end
        PH_THREE: begin byte_o = base_hi_i;   has_data_o = 1'b1; end
        default:  begin byte_o = '0;          has_data_o = 1'b0; end
      endcase
    end
  end
endmodule

// File: rtl/intack_vector_seq.sv
module intack_vector_seq
  import ivs_pkg::*;
#(
  parameter int LVL_W = 3,
  localparam int LO_W = BYTE_W - LVL_W - 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reinit,
  input  logic              ack_i,
  input  logic              ptr_mode_i,
  input  logic              ival4_i,
  input  logic [LO_W-1:0]   base_lo_i,
  input  logic [BYTE_W-1:0] base_hi_i,
  input  logic [LVL_W-1:0]  level_i,
  input  logic              aeoi_i,
  output logic [BYTE_W-1:0] data_o,
  output logic              data_oe_o,
  output logic              freeze_o,
  output logic              eoi_clr_o,
  output logic [LVL_W-1:0]  lvl_o
);
  logic              rise, fall, start, last, mode_eff, mode_q, has_data;
  ph_e               ph_nxt;
  logic [LVL_W-1:0]  lvl_q;
  logic [BYTE_W-1:0] fmt_byte;
  logic [BYTE_W-1:0] data_q;
  logic              oe_q, frz_q, eoi_q;

  ivs_ack_edge u_edge (
    .clk(clk), .rst(rst), .ack_i(ack_i), .rise_o(rise), .fall_o(fall)
  );

  ivs_phase_ctr #(.LVL_W(LVL_W)) u_ctr (
    .clk(clk), .rst(rst), .reinit(reinit), .rise_i(rise), .fall_i(fall),
    .ptr_mode_i(ptr_mode_i), .level_i(level_i), .ph_nxt_o(ph_nxt),
    .mode_eff_o(mode_eff), .mode_o(mode_q), .start_o(start), .last_o(last),
    .lvl_o(lvl_q)
  );

  ivs_byte_fmt #(.LVL_W(LVL_W)) u_fmt (
    .ph_i(ph_nxt), .ptr_mode_i(mode_eff), .ival4_i(ival4_i),
    .base_lo_i(base_lo_i), .base_hi_i(base_hi_i), .lvl_i(lvl_q),
    .byte_o(fmt_byte), .has_data_o(has_data)
  );

  always_ff @(posedge clk) begin
    if (rst || reinit) begin
      data_q <= '0;
      oe_q   <= 1'b0;
      frz_q  <= 1'b0;
      eoi_q  <= 1'b0;
    end else begin
      frz_q <= start;
      eoi_q <= last && aeoi_i;
      if (rise) begin
        data_q <= has_data ? fmt_byte : '0;
        oe_q   <= has_data;
      end else if (fall) begin
        data_q <= '0;
        oe_q   <= 1'b0;
      end
    end
  end

  assign data_o    = data_q;
  assign data_oe_o = oe_q;
  assign freeze_o  = frz_q;
  assign eoi_clr_o = eoi_q;
  assign lvl_o     = lvl_q;

  AST_OE_NEEDS_ACK: assert property (@(posedge clk) disable iff (rst)
    oe_q |-> $past(ack_i)); // R9

  AST_FREEZE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    frz_q |=> !frz_q); // R2

  AST_CALL_FIRST_OPCODE: assert property (@(posedge clk) disable iff (rst)
    (frz_q && !mode_q) |-> (data_q == CALL_OPCODE)); // R2

  AST_PTR_FIRST_SILENT: assert property (@(posedge clk) disable iff (rst)
    (frz_q && mode_q) |-> !oe_q); // R6

  AST_EOI_NEEDS_AEOI: assert property (@(posedge clk) disable iff (rst)
    eoi_q |-> $past(aeoi_i)); // R8

  AST_EOI_SINGLE: assert property (@(posedge clk) disable iff (rst)
    eoi_q |=> !eoi_q); // R8
endmodule

// File: tb/intack_vector_seq_bench.sv
module intack_vector_seq_bench;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       reinit = 1'b0;
  logic       ack = 1'b0;
  logic       ptr_mode = 1'b0;
  logic       ival4 = 1'b0;
  logic [2:0] base_lo = '0;
  logic [7:0] base_hi = '0;
  logic [2:0] level = '0;
  logic       aeoi = 1'b0;
  logic [7:0] data;
  logic       oe, frz, eoi;
  logic [2:0] lvl;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  intack_vector_seq u_intack_vector_seq (
    .clk(clk), .rst(rst), .reinit(reinit), .ack_i(ack), .ptr_mode_i(ptr_mode),
    .ival4_i(ival4), .base_lo_i(base_lo), .base_hi_i(base_hi), .level_i(level),
    .aeoi_i(aeoi), .data_o(data), .data_oe_o(oe), .freeze_o(frz),
    .eoi_clr_o(eoi), .lvl_o(lvl)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  // one acknowledge pulse of two cycles, checked at every step
  task automatic do_pulse(input string tag, input logic eoe, input logic [7:0] edat,
                          input logic efrz, input logic eeoi);
    @(negedge clk) ack = 1'b1;
    @(negedge clk);
    chk({tag, " oe"}, {7'd0, oe}, {7'd0, eoe});
    chk({tag, " data"}, data, edat);
    chk({tag, " freeze"}, {7'd0, frz}, {7'd0, efrz});
    @(negedge clk);
    chk({tag, " freeze drop"}, {7'd0, frz}, 8'd0);
    chk({tag, " data hold"}, data, edat);
    ack = 1'b0;
    @(negedge clk);
    chk({tag, " R9 oe off"}, {7'd0, oe}, 8'd0);
    chk({tag, " R9 data off"}, data, 8'd0);
    chk({tag, " R8 eoi"}, {7'd0, eoi}, {7'd0, eeoi});
    @(negedge clk);
    chk({tag, " R8 eoi drop"}, {7'd0, eoi}, 8'd0);
  endtask

  task automatic t_reset;
    chk("R1 reset data", data, 8'd0);
    chk("R1 reset oe", {7'd0, oe}, 8'd0);
    chk("R1 reset freeze", {7'd0, frz}, 8'd0);
    chk("R1 reset eoi", {7'd0, eoi}, 8'd0);
  endtask

  task automatic t_call_i4;
    ptr_mode = 1'b0; ival4 = 1'b1; base_lo = 3'b101; base_hi = 8'h3C;
    level = 3'd5; aeoi = 1'b0;
    do_pulse("R2 call p1", 1'b1, 8'hCD, 1'b1, 1'b0);
    do_pulse("R3 call p2 i4", 1'b1, 8'hB4, 1'b0, 1'b0);
    do_pulse("R5 call p3", 1'b1, 8'h3C, 1'b0, 1'b0);
  endtask

  task automatic t_call_i8_aeoi;
    ptr_mode = 1'b0; ival4 = 1'b0; base_lo = 3'b011; base_hi = 8'hA5;
    level = 3'd6; aeoi = 1'b1;
    do_pulse("R2 call8 p1", 1'b1, 8'hCD, 1'b1, 1'b0);
    do_pulse("R4 call p2 i8", 1'b1, 8'h70, 1'b0, 1'b0);
    do_pulse("R8 call p3 aeoi", 1'b1, 8'hA5, 1'b0, 1'b1);
    chk("R8 level out", {5'd0, lvl}, 8'd6);
  endtask

  task automatic t_ptr;
    ptr_mode = 1'b1; ival4 = 1'b1; base_hi = 8'hAF; level = 3'd3; aeoi = 1'b1;
    do_pulse("R6 ptr p1", 1'b0, 8'h00, 1'b1, 1'b0);
    ival4 = 1'b0;
    do_pulse("R7 ptr p2", 1'b1, 8'hAB, 1'b0, 1'b1);
    level = 3'd1;
    do_pulse("R11 ptr restart p1", 1'b0, 8'h00, 1'b1, 1'b0);
    do_pulse("R11 ptr restart p2", 1'b1, 8'hA9, 1'b0, 1'b1);
  endtask

  task automatic t_hold;
    ptr_mode = 1'b0; ival4 = 1'b1; base_lo = 3'b000; base_hi = 8'h12;
    level = 3'd2; aeoi = 1'b0;
    do_pulse("R12 hold p1", 1'b1, 8'hCD, 1'b1, 1'b0);
    level = 3'd7; ptr_mode = 1'b1;
    do_pulse("R10 hold p2", 1'b1, 8'h08, 1'b0, 1'b0);
    do_pulse("R12 hold p3", 1'b1, 8'h12, 1'b0, 1'b0);
    ptr_mode = 1'b0;
  endtask

  task automatic t_reinit;
    ptr_mode = 1'b0; ival4 = 1'b1; base_lo = 3'b111; base_hi = 8'h5A;
    level = 3'd0; aeoi = 1'b1;
    do_pulse("R1 pre-reinit p1", 1'b1, 8'hCD, 1'b1, 1'b0);
    @(negedge clk) reinit = 1'b1;
    @(negedge clk) reinit = 1'b0;
    chk("R1 reinit oe", {7'd0, oe}, 8'd0);
    level = 3'd4;
    do_pulse("R1 after reinit p1", 1'b1, 8'hCD, 1'b1, 1'b0);
    do_pulse("R3 after reinit p2", 1'b1, 8'hF0, 1'b0, 1'b0);
    do_pulse("R8 after reinit p3", 1'b1, 8'h5A, 1'b0, 1'b1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_call_i4();
    t_call_i8_aeoi();
    t_ptr();
    t_hold();
    t_reinit();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule